// File: doc/BRIEF.md
# Circular-Pipeline Longest-Prefix-Match Engine

This block resolves IPv4 destination addresses to 8-bit next-hop values. The lookup table is a three-level multibit trie with strides of 16, 8 and 8 bits. The trie lives in one external synchronous RAM, which the block reaches through a request/response port. Each address walks the trie with one to three dependent reads. The walk stops at the first entry that is marked as a leaf.

An accepted address issues its first read straight away. While that read is in flight, the address bits not yet used wait in a small recirculation queue. When the response arrives, the block does one of two things. If the entry is a branch, the block issues the next read and puts the request back in the queue. If the entry is a leaf, the block retires the request to the output queue. Recirculating requests always take the RAM port before new addresses. A new address can still enter in the same cycle that a leaf retires, even when the recirculation queue is full. Each result carries the tag supplied with its address, because results can leave in a different order from the one in which their addresses arrived.

Both stream edges use valid/ready. On the input side, an address transfers on a clock edge where `in_valid` and `in_ready` are both high. Once `in_valid` is raised it must stay high, with its data unchanged, until that edge. `in_ready` never depends on `in_valid`. On the output side, a result transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered result is held unchanged. The block admits a new address only when it has a free place in the output queue reserved for that address's result. For this reason, back-pressure on the output never stalls a memory response.

Top module: `lpm_ring`

## Requirements
- R1: When an address is accepted, `mem_req_valid` is high in that same cycle, and `mem_req_addr` is bits [31:16] of the address, zero-extended.
- R2: A table entry is a flag in bit AW followed by a payload in bits [AW-1:0]. A flag of 1 marks a leaf, and the leaf's next hop is payload bits [7:0]. A leaf reached at level 1 ends the walk after a single read.
- R3: The address of a level-2 read is the payload of the level-1 branch plus address bits [15:8]. The address of a level-3 read is the payload of the level-2 branch plus address bits [7:0].
- R4: A level-3 entry ends the walk whatever its flag says. Its next hop is payload bits [7:0].
- R5: In a cycle where a branch response arrives, the follow-up read is issued in that same cycle, and `in_ready` is low.
- R6: An address can be accepted in the same cycle that a leaf response retires, including when the recirculation queue is full.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_tag` and `out_hop` keep their values into the next cycle.
- R8: Results can leave in an order different from the order of arrival. Each result carries the tag of its own address.
- R9: After reset, `out_valid` and `mem_req_valid` are low and `in_ready` is high.
- R10: Over a run, the number of memory reads equals the sum of the walk depths of all accepted addresses.
- R11: Every accepted address produces exactly one result, however long the output is held back. The recirculation and output queues never overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Block can take an address this cycle |
| in_addr | input | 32 | IPv4 address to look up |
| in_tag | input | TAG_W | Request tag, returned with the result |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_hop | output | 8 | Next-hop value |
| out_tag | output | TAG_W | Tag of the request this result answers |
| mem_req_valid | output | 1 | RAM read request |
| mem_req_addr | output | AW | RAM read address |
| mem_rsp_valid | input | 1 | RAM read data valid |
| mem_rsp_data | input | AW+1 | RAM entry: leaf flag in bit AW, payload below it |

## Verification
The assertions make four assumptions about the inputs. First, the RAM returns exactly one response for each request, in request order, after a fixed delay. Second, no response ever arrives without an outstanding request. Third, a raised `in_valid` holds until the address is taken. Fourth, tags are unique among the requests in flight.

The bench meets all four. It models the RAM as a fixed three-stage pipeline whose contents are computed arithmetically. It holds every offer until it is accepted. It uses sequence numbers as tags, and the queue reservation caps the number of requests in flight far below the tag space.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int HOP_W  = 8;   // next-hop width
  localparam int ROOT_W = 16;  // first-stride width
  localparam int STRIDE = 8;   // later strides
  localparam int REM_W  = 2 * STRIDE;

  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_ONE  = 2'd1,
    LV_TWO  = 2'd2,
    LV_LAST = 2'd3
  } lvl_t;
endpackage

// File: rtl/lpm_fifo.sv
module lpm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  // Push while full is legal when pop happens in the same cycle.
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rp, wp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  assign dout = slots[rp];
endmodule

// File: rtl/lpm_step.sv
module lpm_step import lpm_pkg::*; #(
  parameter int AW = 17,
  localparam int EW = AW + 1
) (
  input  logic [EW-1:0]    rsp,
  input  logic [REM_W-1:0] rem,
  input  lvl_t             lvl,
  output logic             leaf,
  output logic [HOP_W-1:0] hop,
  output logic [AW-1:0]    nxt_addr,
  output logic [REM_W-1:0] nxt_rem,
  output lvl_t             nxt_lvl
);
  // Final level terminates the walk regardless of the flag.
  assign leaf     = rsp[EW-1] || (lvl == LV_LAST);
  assign hop      = rsp[HOP_W-1:0];
  assign nxt_addr = rsp[AW-1:0] + AW'(rem[REM_W-1:STRIDE]);
  assign nxt_rem  = {rem[STRIDE-1:0], {STRIDE{1'b0}}};

  always_comb begin
    case (lvl)
      LV_ONE:  nxt_lvl = LV_TWO;
      LV_TWO:  nxt_lvl = LV_LAST;
      default: nxt_lvl = LV_LAST;
    endcase
  end
endmodule

// File: rtl/lpm_ring.sv
module lpm_ring import lpm_pkg::*; #(
  parameter int AW       = 17,
  parameter int TAG_W    = 8,
  parameter int RC_DEPTH = 4,
  parameter int OQ_DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_addr,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [HOP_W-1:0] out_hop,
  output logic [TAG_W-1:0] out_tag,
  output logic             mem_req_valid,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW:0]      mem_rsp_data
);
  localparam int RC_W = TAG_W + REM_W + 2;
  localparam int OQ_W = TAG_W + HOP_W;
  localparam int RCC  = $clog2(RC_DEPTH + 1);
  localparam int OQC  = $clog2(OQ_DEPTH + 1);
  localparam int SW   = $clog2(RC_DEPTH + OQ_DEPTH + 1);

  logic [RC_W-1:0]  rc_din, rc_dout;
  logic [RCC-1:0]   rc_count;
  logic [OQ_W-1:0]  oq_dout;
  logic [OQC-1:0]   oq_count;
  logic [TAG_W-1:0] h_tag;
  logic [REM_W-1:0] h_rem, nxt_rem;
  lvl_t             h_lvl, nxt_lvl;
  logic             leaf, recirc, retire, enter, out_pop, rc_room, oq_room;
  logic [HOP_W-1:0] hop;
  logic [AW-1:0]    nxt_addr;
  logic [SW-1:0]    reserved;

  assign h_tag = rc_dout[RC_W-1 -: TAG_W];
  assign h_rem = rc_dout[REM_W+1:2];
  assign h_lvl = lvl_t'(rc_dout[1:0]);

  lpm_step #(.AW(AW)) u_step (
    .rsp(mem_rsp_data), .rem(h_rem), .lvl(h_lvl),
    .leaf(leaf), .hop(hop), .nxt_addr(nxt_addr),
    .nxt_rem(nxt_rem), .nxt_lvl(nxt_lvl)
  );

  assign recirc  = mem_rsp_valid && !leaf;
  assign retire  = mem_rsp_valid && leaf;
  assign out_pop = out_valid && out_ready;

  // Every request in flight or waiting at the output holds one output place.
  assign reserved = SW'(rc_count) + SW'(oq_count);
  assign rc_room  = (rc_count < RCC'(RC_DEPTH)) || retire;
  assign oq_room  = (reserved < SW'(OQ_DEPTH)) || out_pop;
  assign in_ready = !recirc && rc_room && oq_room;
  assign enter    = in_valid && in_ready;

  assign rc_din = recirc ? {h_tag, nxt_rem, nxt_lvl}
                         : {in_tag, in_addr[REM_W-1:0], LV_ONE};

  lpm_fifo #(.W(RC_W), .DEPTH(RC_DEPTH)) u_rc (
    .clk(clk), .rst_n(rst_n),
    .push(enter || recirc), .pop(mem_rsp_valid),
    .din(rc_din), .dout(rc_dout), .count(rc_count)
  );

  lpm_fifo #(.W(OQ_W), .DEPTH(OQ_DEPTH)) u_oq (
    .clk(clk), .rst_n(rst_n),
    .push(retire), .pop(out_pop),
    .din({h_tag, hop}), .dout(oq_dout), .count(oq_count)
  );

  assign out_valid     = (oq_count != '0);
  assign out_tag       = oq_dout[OQ_W-1 -: TAG_W];
  assign out_hop       = oq_dout[HOP_W-1:0];
  assign mem_req_valid = enter || recirc;
  assign mem_req_addr  = recirc ? nxt_addr : AW'(in_addr[31:ROOT_W]);
endmodule

// File: rtl/lpm_ring_chk.sv
module lpm_ring_chk #(
  parameter int AW       = 17,
  parameter int TAG_W    = 8,
  parameter int RC_DEPTH = 4,
  parameter int OQ_DEPTH = 6,
  localparam int RCC     = $clog2(RC_DEPTH + 1),
  localparam int OQC     = $clog2(OQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [31:0]      in_addr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_hop,
  input logic [TAG_W-1:0] out_tag,
  input logic             mem_req_valid,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [AW:0]      mem_rsp_data,
  input logic [1:0]       head_lvl,
  input logic [RCC-1:0]   rc_count,
  input logic [OQC-1:0]   oq_count
);
  p_enter_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (mem_req_valid && mem_req_addr == AW'(in_addr[31:16])));

  p_recirc_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !mem_rsp_data[AW] && head_lvl != 2'd3) |-> (!in_ready && mem_req_valid));

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_hop)));

  p_rc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rc_count <= RCC'(RC_DEPTH));

  p_oq_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oq_count <= OQC'(OQ_DEPTH));

  p_no_orphan_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (rc_count != '0));
endmodule

bind lpm_ring lpm_ring_chk #(
  .AW(AW), .TAG_W(TAG_W), .RC_DEPTH(RC_DEPTH), .OQ_DEPTH(OQ_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_hop(out_hop), .out_tag(out_tag), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data(mem_rsp_data), .head_lvl(h_lvl),
  .rc_count(rc_count), .oq_count(oq_count)
);

// File: tb/test_lpm_ring.sv
module test_lpm_ring;
  localparam int AW    = 17;
  localparam int TAG_W = 8;
  localparam int LAT   = 3;
  localparam int N     = 1200;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_addr;
  logic [TAG_W-1:0] in_tag, out_tag;
  logic [7:0] out_hop;
  logic mem_req_valid, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [AW:0] mem_rsp_data;

  always #10 clk = ~clk;

  lpm_ring #(.AW(AW), .TAG_W(TAG_W)) i_lpm_ring (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_tag(in_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_hop(out_hop), .out_tag(out_tag),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Table computed arithmetically: root 0..FFFF, level two at 10000, level three at 10400.
  function automatic logic [AW:0] tbl(input logic [AW-1:0] a);
    logic [AW-1:0] j;
    if (a < 17'h10000) begin
      if (a[1:0] == 2'b00) return {1'b0, 17'h10000 + {7'b0, a[3:2], 8'h00}};
      return {1'b1, 9'b0, a[7:0] ^ 8'h5A};
    end else if (a < 17'h10400) begin
      j = a - 17'h10000;
      if (j[7:0] % 8'd3 == 8'd0) return {1'b0, 17'h10400 + {7'b0, j[1:0], 8'h00}};
      return {1'b1, 9'b0, j[7:0] + 8'(j[9:8]) * 8'd17};
    end
    j = a - 17'h10400;
    return {j[0], 9'b0, j[7:0] * 8'd3 + 8'(j[9:8])};
  endfunction

  function automatic void walk(input logic [31:0] ad, output logic [7:0] hop, output int dep);
    logic [AW:0] e;
    e = tbl({1'b0, ad[31:16]});
    dep = 1;
    if (!e[AW]) begin
      e = tbl(e[AW-1:0] + {9'b0, ad[15:8]});
      dep = 2;
      if (!e[AW]) begin
        e = tbl(e[AW-1:0] + {9'b0, ad[7:0]});
        dep = 3;
      end
    end
    hop = e[7:0];
  endfunction

  function automatic logic [31:0] mk_addr(input int n);
    logic [15:0] hi;
    hi = 16'(n * 4 + ((n % 5 == 0) ? 1 : 0));
    return {hi, 8'(n * 11 + n / 7), 8'(n * 5 + 3)};
  endfunction

  // Fixed-latency RAM model.
  logic [LAT-1:0] pv;
  logic [AW-1:0]  pa [LAT];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[LAT-2:0], mem_req_valid};
  end
  always_ff @(posedge clk) begin
    pa[0] <= mem_req_addr;
    for (int i = 1; i < LAT; i++) pa[i] <= pa[i-1];
  end
  assign mem_rsp_valid = pv[LAT-1];
  assign mem_rsp_data  = tbl(pa[LAT-1]);

  int checks = 0, errs = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] exp_hop [256];
  int         exp_dep [256];
  bit         pend    [256];
  int sent = 0, rcv = 0, cyc = 0, reads = 0, exp_reads = 0, same_cyc = 0, ooo = 0;
  bit acc = 0, hold = 0;
  logic [7:0] p_tag, p_hop;
  logic [15:0] lf = 16'hACE1;

  initial begin
    for (int i = 0; i < 256; i++) pend[i] = 0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_addr = '0; in_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R9 out_valid", int'(out_valid), 0);
    chk(!mem_req_valid, "R9 mem_req_valid", int'(mem_req_valid), 0);
    chk(in_ready, "R9 in_ready", int'(in_ready), 1);

    while ((sent < N || rcv < sent) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (acc) begin
        in_valid = 1'b0;
        acc = 0;
      end
      if (!in_valid && sent < N && (sent < N / 3 || lf[5] || lf[2])) begin
        in_valid = 1'b1;
        in_addr  = mk_addr(sent);
        in_tag   = 8'(sent);
      end
      out_ready = (sent < N / 3) ? 1'b1 : (lf[0] | lf[3]);
      #1;
      if (mem_req_valid) reads++;
      // R5: a branch response from level one or two blocks entry and reissues.
      if (mem_rsp_valid && !mem_rsp_data[AW] && pa[LAT-1] < 17'h10400)
        chk(!in_ready && mem_req_valid, "R5 recirc priority", int'({in_ready, mem_req_valid}), 1);
      if (mem_rsp_valid && mem_rsp_data[AW] && in_valid && in_ready) same_cyc++;
      if (hold)
        chk(out_valid && out_tag == p_tag && out_hop == p_hop, "R7 hold",
            int'({out_valid, out_tag, out_hop}), int'({1'b1, p_tag, p_hop}));
      hold  = out_valid && !out_ready;
      p_tag = out_tag;
      p_hop = out_hop;
      if (out_valid && out_ready) begin
        if (!pend[out_tag]) chk(0, "R11 unexpected tag", int'(out_tag), -1);
        else begin
          case (exp_dep[out_tag])
            1:       chk(out_hop == exp_hop[out_tag], "R2 level-1 leaf", int'(out_hop), int'(exp_hop[out_tag]));
            2:       chk(out_hop == exp_hop[out_tag], "R3 level-2 leaf", int'(out_hop), int'(exp_hop[out_tag]));
            default: chk(out_hop == exp_hop[out_tag], "R4 level-3 entry", int'(out_hop), int'(exp_hop[out_tag]));
          endcase
          pend[out_tag] = 0;
        end
        if (out_tag != 8'(rcv)) ooo++;
        rcv++;
      end
      if (in_valid && in_ready) begin
        logic [7:0] h;
        int d;
        chk(mem_req_valid && mem_req_addr == {1'b0, in_addr[31:16]}, "R1 root read",
            int'(mem_req_addr), int'(in_addr[31:16]));
        walk(in_addr, h, d);
        exp_hop[in_tag] = h;
        exp_dep[in_tag] = d;
        pend[in_tag] = 1;
        exp_reads += d;
        sent++;
        acc = 1;
      end
    end

    if (cyc >= LIMIT) chk(0, "R11 watchdog", cyc, LIMIT);
    chk(rcv == N && sent == N, "R11 all results", rcv, N);
    chk(reads == exp_reads, "R10 read count", reads, exp_reads);
    chk(same_cyc > 0, "R6 entry with retire", same_cyc, 1);
    chk(ooo > 0, "R8 reordering seen", ooo, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule